// File: doc/BRIEF.md
# CAN Message Box Acceptance Selector

This block picks the message box that stores each received CAN frame, and it picks the next box to transmit. It holds up to 16 boxes. Each box has an enable, a direction (receive or transmit), a format (standard or extended) and an identifier. Two group filters can each cover one box with a don't-care mask, so that a single box accepts a whole range of identifiers. When a group box accepts a frame, its stored identifier is replaced by the received one.

A received frame is presented as one strobe that carries a 29-bit identifier and an extended flag. A standard identifier sits in bits 28:18, and bits 17:0 are ignored for standard frames. Two clock edges after the strobe, the block reports a hit flag and the index of the winning box. The block also has a pending-request vector for transmit boxes. From it, a registered output gives the lowest pending box in every cycle.

Top module: `can_box_selector`

## Requirements
- R1: Boxes whose index is greater than `hi_box_i` never accept a frame and are never chosen for transmit.
- R2: When several boxes match, the box with the lowest index wins. `hit_o` is 1 and `box_o` is that index.
- R3: `tx_valid_o` and `tx_box_o` name the lowest-indexed box that is enabled, in transmit direction, in range and pending in `tx_pend_i`. They are registered one edge after the inputs.
- R4: A box matches only frames whose `rx_ext_i` equals its format bit (1 = extended). Extended boxes compare all 29 bits. Standard boxes compare only bits 28:18.
- R5: Each of the two group filters is in effect only while its enable bit is 1. An enabled filter applies its mask to the box named in its 4-bit box field, and a mask bit of 1 makes that identifier bit don't-care.
- R6: When a frame is accepted by a box covered by an enabled group filter, `id_upd_o` pulses with the result and that box's stored identifier becomes the received identifier. Other boxes are never rewritten.
- R7: A box whose bit in `lock_i` is 1 at the strobe is excluded from matching, and the frame goes to the next matching box.
- R8: `done_o` pulses for one cycle two edges after `rx_valid_i`. `hit_o` and `box_o` hold their value until the next result.
- R9: On a miss, `hit_o` is 0, `box_o` is 0, `id_upd_o` stays 0 and no stored identifier changes.
- R10: Disabled boxes and transmit-direction boxes never accept a received frame, and receive boxes are never chosen for transmit.
- R11: After reset, `done_o`, `hit_o`, `id_upd_o` and `tx_valid_o` are 0, and all boxes and group filters are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Write box configuration |
| cfg_box_i | input | 4 | Box index to configure |
| cfg_en_i | input | 1 | Box enable |
| cfg_tx_i | input | 1 | Direction, 1 = transmit |
| cfg_ext_i | input | 1 | Format, 1 = extended |
| cfg_id_i | input | 29 | Box identifier (standard in 28:18) |
| grp_we_i | input | 1 | Write group filter |
| grp_sel_i | input | 1 | Group filter index |
| grp_en_i | input | 1 | Group filter enable |
| grp_box_i | input | 4 | Box covered by the group filter |
| grp_mask_i | input | 29 | Don't-care mask, 1 = ignore bit |
| hi_box_i | input | 4 | Highest box index in use |
| lock_i | input | 16 | Host access grant per box |
| tx_pend_i | input | 16 | Pending transmit request per box |
| rx_valid_i | input | 1 | Received identifier strobe |
| rx_id_i | input | 29 | Received identifier |
| rx_ext_i | input | 1 | Received frame is extended |
| rd_box_i | input | 4 | Box index for identifier read |
| rd_id_o | output | 29 | Stored identifier of `rd_box_i` |
| done_o | output | 1 | Result strobe |
| hit_o | output | 1 | Frame accepted |
| box_o | output | 4 | Accepting box index |
| id_upd_o | output | 1 | Group box identifier was replaced |
| tx_valid_o | output | 1 | A transmit box is selected |
| tx_box_o | output | 4 | Selected transmit box |

## Verification
In every cycle, the assertions check these things: the reported winner was a matching box and no lower-indexed box matched, the transmit pick is lowest and in range, a locked box never wins, the result strobe follows the identifier strobe by two edges, and an identifier rewrite happens only for a group box on a hit. Only the bench scenarios can show that the match itself is right. This covers format separation, the ignored low bits on standard frames, the mask ranges, the effect of the group enables and the box limit. The scenarios also show that a rewritten identifier reads back correctly and that a miss leaves stored identifiers unchanged.

// File: rtl/can_box_pkg.sv
package can_box_pkg;
  localparam int ID_W  = 29;
  localparam int STD_W = 11;
  localparam logic [ID_W-1:0] STD_FIELD = {{STD_W{1'b1}}, {(ID_W-STD_W){1'b0}}};

  typedef struct packed {
    logic            en;
    logic            tx;
    logic            ext;
    logic [ID_W-1:0] id;
  } box_cfg_t;
endpackage

// File: rtl/can_box_cmp.sv
module can_box_cmp
  import can_box_pkg::*;
(
  input  box_cfg_t        cfg_i,
  input  logic [ID_W-1:0] dc_mask_i,
  input  logic [ID_W-1:0] rx_id_i,
  input  logic            rx_ext_i,
  output logic            match_o
);
  logic [ID_W-1:0] care;

  always_comb begin
    care    = ~dc_mask_i & (cfg_i.ext ? {ID_W{1'b1}} : STD_FIELD);
    match_o = cfg_i.en & ~cfg_i.tx & (cfg_i.ext == rx_ext_i) &
              (((cfg_i.id ^ rx_id_i) & care) == '0);
  end
endmodule

// File: rtl/can_lowest_sel.sv
module can_lowest_sel #(
  parameter int N = 16,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = W'(i);
      end
    end
  end
endmodule

// File: rtl/can_box_selector.sv
module can_box_selector
  import can_box_pkg::*;
#(
  parameter int NUM_BOX = 16,
  parameter int NUM_GRP = 2,
  localparam int BOX_W = $clog2(NUM_BOX),
  localparam int GRP_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [BOX_W-1:0]   cfg_box_i,
  input  logic               cfg_en_i,
  input  logic               cfg_tx_i,
  input  logic               cfg_ext_i,
  input  logic [ID_W-1:0]    cfg_id_i,
  input  logic               grp_we_i,
  input  logic [GRP_W-1:0]   grp_sel_i,
  input  logic               grp_en_i,
  input  logic [BOX_W-1:0]   grp_box_i,
  input  logic [ID_W-1:0]    grp_mask_i,
  input  logic [BOX_W-1:0]   hi_box_i,
  input  logic [NUM_BOX-1:0] lock_i,
  input  logic [NUM_BOX-1:0] tx_pend_i,
  input  logic               rx_valid_i,
  input  logic [ID_W-1:0]    rx_id_i,
  input  logic               rx_ext_i,
  input  logic [BOX_W-1:0]   rd_box_i,
  output logic [ID_W-1:0]    rd_id_o,
  output logic               done_o,
  output logic               hit_o,
  output logic [BOX_W-1:0]   box_o,
  output logic               id_upd_o,
  output logic               tx_valid_o,
  output logic [BOX_W-1:0]   tx_box_o
);
  box_cfg_t          cfg_q [NUM_BOX];
  logic              grp_en_q   [NUM_GRP];
  logic [BOX_W-1:0]  grp_box_q  [NUM_GRP];
  logic [ID_W-1:0]   grp_mask_q [NUM_GRP];

  logic [ID_W-1:0]   dc_mask [NUM_BOX];
  logic [NUM_BOX-1:0] is_grp, in_range, cmp_hit, match_d, match_q, tx_ok;
  logic [ID_W-1:0]   rx_id_q;
  logic              pend_q;
  logic              rx_any, tx_any;
  logic [BOX_W-1:0]  rx_win, tx_win;
  logic              upd_now;

  // Group resolution: group 0 takes precedence when both name one box
  always_comb begin
    for (int b = 0; b < NUM_BOX; b++) begin
      dc_mask[b]  = '0;
      is_grp[b]   = 1'b0;
      in_range[b] = (BOX_W'(b) <= hi_box_i);
      for (int g = NUM_GRP - 1; g >= 0; g--) begin
        if (grp_en_q[g] && grp_box_q[g] == BOX_W'(b)) begin
          dc_mask[b] = grp_mask_q[g];
          is_grp[b]  = 1'b1;
        end
      end
    end
  end

  for (genvar b = 0; b < NUM_BOX; b++) begin : g_cmp
    can_box_cmp u_cmp (
      .cfg_i     (cfg_q[b]),
      .dc_mask_i (dc_mask[b]),
      .rx_id_i   (rx_id_i),
      .rx_ext_i  (rx_ext_i),
      .match_o   (cmp_hit[b])
    );
    assign match_d[b] = cmp_hit[b] & in_range[b] & ~lock_i[b];
    assign tx_ok[b]   = tx_pend_i[b] & cfg_q[b].en & cfg_q[b].tx & in_range[b];
  end

  can_lowest_sel #(.N(NUM_BOX)) u_rx_sel (
    .req_i (match_q), .any_o (rx_any), .idx_o (rx_win)
  );
  can_lowest_sel #(.N(NUM_BOX)) u_tx_sel (
    .req_i (tx_ok), .any_o (tx_any), .idx_o (tx_win)
  );

  assign upd_now = pend_q & rx_any & is_grp[rx_win];

  // Stage 0: capture match vector and identifier
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= '0;
      rx_id_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      pend_q <= rx_valid_i;
      if (rx_valid_i) begin
        match_q <= match_d;
        rx_id_q <= rx_id_i;
      end
    end
  end

  // Stage 1: result
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      hit_o    <= 1'b0;
      box_o    <= '0;
      id_upd_o <= 1'b0;
    end else begin
      done_o   <= pend_q;
      id_upd_o <= upd_now;
      if (pend_q) begin
        hit_o <= rx_any;
        box_o <= rx_any ? rx_win : '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_o <= 1'b0;
      tx_box_o   <= '0;
    end else begin
      tx_valid_o <= tx_any;
      tx_box_o   <= tx_win;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NUM_BOX; b++) cfg_q[b] <= '0;
    end else begin
      if (cfg_we_i) cfg_q[cfg_box_i] <= '{en: cfg_en_i, tx: cfg_tx_i,
                                          ext: cfg_ext_i, id: cfg_id_i};
      if (upd_now) cfg_q[rx_win].id <= rx_id_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int g = 0; g < NUM_GRP; g++) begin
        grp_en_q[g]   <= 1'b0;
        grp_box_q[g]  <= '0;
        grp_mask_q[g] <= '0;
      end
    end else if (grp_we_i) begin
      grp_en_q[grp_sel_i]   <= grp_en_i;
      grp_box_q[grp_sel_i]  <= grp_box_i;
      grp_mask_q[grp_sel_i] <= grp_mask_i;
    end
  end

  assign rd_id_o = cfg_q[rd_box_i].id;

  // Assertions
  a_r8_done_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |-> ##2 done_o);
  a_r2_winner_matched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && hit_o |-> ((($past(match_q) >> box_o) & NUM_BOX'(1)) != '0));
  a_r2_no_lower_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && hit_o |->
      (($past(match_q) & ((NUM_BOX'(1) << box_o) - NUM_BOX'(1))) == '0));
  a_r9_miss_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !hit_o |-> !id_upd_o && box_o == '0);
  a_r6_upd_group_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_upd_o |-> hit_o && ((($past(is_grp) >> box_o) & NUM_BOX'(1)) != '0));
  a_r6_upd_stores_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_upd_o && !$past(cfg_we_i) |-> cfg_q[box_o].id == $past(rx_id_q));
  a_r7_locked_loses: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && hit_o |-> ((($past(lock_i, 2) >> box_o) & NUM_BOX'(1)) == '0));
  a_r3_tx_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> ((($past(tx_ok) >> tx_box_o) & NUM_BOX'(1)) != '0) &&
                   (($past(tx_ok) & ((NUM_BOX'(1) << tx_box_o) - NUM_BOX'(1))) == '0));
  a_r1_tx_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> tx_box_o <= $past(hi_box_i));
endmodule

// File: tb/can_box_selector_tb_top.sv
`timescale 1ns/1ps
module can_box_selector_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 0, cfg_en_i = 0, cfg_tx_i = 0, cfg_ext_i = 0;
  logic [3:0]  cfg_box_i = 0;
  logic [28:0] cfg_id_i = 0;
  logic        grp_we_i = 0, grp_sel_i = 0, grp_en_i = 0;
  logic [3:0]  grp_box_i = 0;
  logic [28:0] grp_mask_i = 0;
  logic [3:0]  hi_box_i = 4'hF;
  logic [15:0] lock_i = 0, tx_pend_i = 0;
  logic        rx_valid_i = 0, rx_ext_i = 0;
  logic [28:0] rx_id_i = 0;
  logic [3:0]  rd_box_i = 0;
  logic [28:0] rd_id_o;
  logic        done_o, hit_o, id_upd_o, tx_valid_o;
  logic [3:0]  box_o, tx_box_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  can_box_selector dut_i (.*);

  // {id, ext, hit, upd, box}
  localparam int VEC_N = 12;
  localparam logic [35:0] VEC [VEC_N] = '{
    {11'h123, 18'h0,     1'b0, 1'b1, 1'b0, 4'd0},
    {29'h0ABCDEF,        1'b1, 1'b1, 1'b0, 4'd2},
    {11'h200, 18'h0,     1'b0, 1'b0, 1'b0, 4'd0},
    {11'h300, 18'h0,     1'b0, 1'b0, 1'b0, 4'd0},
    {11'h407, 18'h0,     1'b0, 1'b1, 1'b1, 4'd6},
    {29'h10000AB,        1'b1, 1'b1, 1'b1, 4'd10},
    {11'h123, 18'h0,     1'b1, 1'b0, 1'b0, 4'd0},
    {11'h050, 18'h0,     1'b0, 1'b1, 1'b0, 4'd5},
    {11'h7FF, 18'h0,     1'b0, 1'b0, 1'b0, 4'd0},
    {29'h1234567,        1'b1, 1'b1, 1'b0, 4'd9},
    {11'h123, 18'h155,   1'b0, 1'b1, 1'b0, 4'd0},
    {29'h10000FF,        1'b1, 1'b1, 1'b1, 4'd10}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_box(input int b, input bit en, input bit tx, input bit ext,
                         input logic [28:0] id);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_box_i = 4'(b); cfg_en_i = en; cfg_tx_i = tx;
    cfg_ext_i = ext; cfg_id_i = id;
    @(negedge clk_i);
    cfg_we_i = 0;
  endtask

  task automatic set_grp(input bit g, input bit en, input int b, input logic [28:0] m);
    @(negedge clk_i);
    grp_we_i = 1; grp_sel_i = g; grp_en_i = en; grp_box_i = 4'(b); grp_mask_i = m;
    @(negedge clk_i);
    grp_we_i = 0;
  endtask

  // Returns at the negedge after the result edge
  task automatic send(input logic [28:0] id, input bit ext);
    @(negedge clk_i);
    rx_valid_i = 1; rx_id_i = id; rx_ext_i = ext;
    @(negedge clk_i);
    rx_valid_i = 0;
    @(negedge clk_i);
  endtask

  task automatic read_id(input int b, output logic [28:0] v);
    rd_box_i = 4'(b);
    #0.1 v = rd_id_o;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    logic [28:0] v;
    repeat (3) @(negedge clk_i);
    chk("R11 done", done_o, 0);
    chk("R11 hit", hit_o, 0);
    chk("R11 tx_valid", tx_valid_o, 0);
    chk("R11 upd", id_upd_o, 0);
    rst_ni = 1;
    send({11'h123, 18'h0}, 0);
    chk("R11 unconfigured box miss", hit_o, 0);

    set_box(0,  1, 0, 0, {11'h123, 18'h0});
    set_box(1,  1, 0, 0, {11'h123, 18'h0});
    set_box(2,  1, 0, 1, 29'h0ABCDEF);
    set_box(3,  1, 1, 0, {11'h200, 18'h0});
    set_box(4,  0, 0, 0, {11'h300, 18'h0});
    set_box(5,  1, 0, 0, {11'h050, 18'h0});
    set_box(6,  1, 0, 0, {11'h400, 18'h0});
    set_box(7,  1, 1, 1, 29'h0ABCDEF);
    set_box(9,  1, 0, 1, 29'h1234567);
    set_box(10, 1, 0, 1, 29'h1000000);
    set_grp(0, 1, 6,  {7'h0, 4'hF, 18'h0});
    set_grp(1, 1, 10, 29'hFF);

    // R2 R4 R5 R6 R10 table
    for (int i = 0; i < VEC_N; i++) begin
      send(VEC[i][35:7], VEC[i][6]);
      chk($sformatf("R2 vec %0d done", i), done_o, 1);
      chk($sformatf("R2 vec %0d hit", i), hit_o, VEC[i][5]);
      chk($sformatf("R2 vec %0d box", i), box_o, VEC[i][3:0]);
      chk($sformatf("R6 vec %0d upd", i), id_upd_o, VEC[i][4]);
      if (i == 4) begin
        read_id(6, v);
        chk("R6 group id replaced", v, {11'h407, 18'h0});
      end
    end
    read_id(10, v);
    chk("R6 group1 id replaced", v, 29'h10000FF);
    read_id(2, v);
    chk("R6 non-group id kept", v, 29'h0ABCDEF);

    // R9 miss leaves state
    send({11'h7FF, 18'h0}, 0);
    chk("R9 miss hit", hit_o, 0);
    chk("R9 miss box", box_o, 0);
    chk("R9 miss upd", id_upd_o, 0);
    read_id(0, v);
    chk("R9 box0 id kept", v, {11'h123, 18'h0});
    read_id(6, v);
    chk("R9 box6 id kept", v, {11'h407, 18'h0});

    // R8 timing and hold
    @(negedge clk_i);
    rx_valid_i = 1; rx_id_i = 29'h1234567; rx_ext_i = 1;
    @(negedge clk_i);
    rx_valid_i = 0;
    chk("R8 no early done", done_o, 0);
    @(negedge clk_i);
    chk("R8 done at two edges", done_o, 1);
    chk("R8 box", box_o, 9);
    repeat (3) @(negedge clk_i);
    chk("R8 done one pulse", done_o, 0);
    chk("R8 hit held", hit_o, 1);
    chk("R8 box held", box_o, 9);

    // R7 lock
    lock_i = 16'h0001;
    send({11'h123, 18'h0}, 0);
    chk("R7 lock skip hit", hit_o, 1);
    chk("R7 lock skip box", box_o, 1);
    lock_i = 16'h0003;
    send({11'h123, 18'h0}, 0);
    chk("R7 all locked miss", hit_o, 0);
    lock_i = 0;

    // R1 range
    hi_box_i = 4;
    send({11'h050, 18'h0}, 0);
    chk("R1 above range miss", hit_o, 0);
    send({11'h123, 18'h0}, 0);
    chk("R1 in range box", box_o, 0);
    hi_box_i = 4'hF;

    // R5 group disable
    set_grp(0, 0, 6, {7'h0, 4'hF, 18'h0});
    send({11'h40A, 18'h0}, 0);
    chk("R5 disabled group miss", hit_o, 0);
    send({11'h407, 18'h0}, 0);
    chk("R5 exact match still", box_o, 6);
    chk("R5 no upd when group off", id_upd_o, 0);

    // R3 transmit pick
    @(negedge clk_i); tx_pend_i = 16'h0088;
    @(negedge clk_i);
    chk("R3 tx valid", tx_valid_o, 1);
    chk("R3 tx lowest", tx_box_o, 3);
    tx_pend_i = 16'h0080;
    @(negedge clk_i);
    chk("R3 tx next", tx_box_o, 7);
    tx_pend_i = 16'h0081;
    @(negedge clk_i);
    chk("R10 rx box not sent", tx_box_o, 7);
    tx_pend_i = 16'h0080; hi_box_i = 5;
    @(negedge clk_i);
    chk("R1 tx out of range", tx_valid_o, 0);
    hi_box_i = 4'hF; tx_pend_i = 16'h0001;
    @(negedge clk_i);
    chk("R10 rx-only pend", tx_valid_o, 0);
    tx_pend_i = 0;

    summary();
  end
endmodule